// File: doc/BRIEF.md
# Threshold FIFO Transfer Request Controller

This block holds a small byte FIFO between a disk-style device engine and a host bus, and decides when the host side should be asked for service. Data flows in one of two directions. In the read direction the device pushes bytes and the host drains them. In the write direction the host fills the FIFO and the device consumes it. The host is served either by a DMA engine or by programmed I/O. In DMA mode the block drives a DMA request with an acknowledge handshake. In programmed I/O mode it drives an interrupt line and a ready-for-master status bit.

A programmable threshold sets how early a request is raised, which trades request frequency against the latency the host may take. The request logic is a four-state machine. `ST_IDLE` is outside the execution phase. In `ST_WAIT` no request is shown and the controller waits for the threshold or for sector completion. In `ST_SERVE` the request is shown. In `ST_END` the transfer has been terminated and the block waits for the result phase. The transitions are as follows. IDLE→WAIT or IDLE→SERVE happens on entry to the execution phase. WAIT→SERVE happens when the trigger level is met. SERVE→WAIT happens on empty (read) or full (write). WAIT or SERVE goes to END on terminal count. Any state goes to IDLE when the execution phase drops or a command starts.

Top module: `fifo_svc_req`

## Requirements
- R1: After reset, drq, irq, rqm, result_ok, overrun and underrun are 0, and level is 0.
- R2: The FIFO (DEPTH=16 bytes) returns bytes in write order, and level counts them. A push while full and a pop while empty are ignored and leave level unchanged. cmd_start empties the FIFO.
- R3: In the read direction (dir_rd=1), the request is shown from the clock edge at which level reaches DEPTH − threshold.
- R4: In the read direction, pushing a byte with last_sector_byte=1 shows the request from that edge, even below the threshold level.
- R5: In the read direction, the request stays shown while bytes remain, and is withdrawn at the edge where level becomes 0.
- R6: In the write direction (dir_rd=0), the request is shown at the first edge with exec_phase=1 and the FIFO not full. It stays shown until the edge where level becomes DEPTH.
- R7: In the write direction, after a full condition, the request is shown again at the edge where level falls to the threshold or below.
- R8: With dma_mode=1 the request appears only on drq. With dma_mode=0 it appears on irq and on rqm, and drq stays 0.
- R9: In DMA mode, with tc=1, a rising edge of dma_ack withdraws drq. If dma_ack is already held high, drq is instead withdrawn at the host strobe: host_rd when reading, host_wr when writing. tc without dma_ack has no effect.
- R10: In programmed I/O mode, tc=1 while dma_ack=0 withdraws irq and rqm for the rest of the command.
- R11: result_ok is 1 only once the transfer has been terminated and the FIFO is empty.
- R12: thr_val is loaded only when thr_wr=1. A value of 0 is stored as 1.
- R13: overrun sets when host_wr=1 with dir_rd=0 and the FIFO full. underrun sets when host_rd=1 with dir_rd=1 and the FIFO empty. Both flags hold until cmd_start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start of command: flushes FIFO, clears flags, returns to idle |
| exec_phase | input | 1 | Execution phase of a data transfer command |
| dir_rd | input | 1 | 1 = device to host, 0 = host to device |
| dma_mode | input | 1 | 1 = DMA service, 0 = programmed I/O |
| thr_wr | input | 1 | Load strobe for the threshold |
| thr_val | input | TW (4) | Threshold value to load |
| dev_push | input | 1 | Device pushes a byte (read direction) |
| dev_wdata | input | DW (8) | Byte pushed by the device |
| last_sector_byte | input | 1 | Marks the pushed byte as the last of a sector |
| dev_pop | input | 1 | Device takes a byte (write direction) |
| dev_rdata | output | DW (8) | Head byte of the FIFO, device side |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_wdata | input | DW (8) | Byte written by the host |
| host_rdata | output | DW (8) | Head byte of the FIFO, host side |
| dma_ack | input | 1 | DMA acknowledge, active high |
| tc | input | 1 | Terminal count |
| drq | output | 1 | DMA request |
| irq | output | 1 | Interrupt request (programmed I/O) |
| rqm | output | 1 | Ready-for-master status bit (programmed I/O) |
| result_ok | output | 1 | Result phase may begin |
| overrun | output | 1 | Sticky host write to a full FIFO |
| underrun | output | 1 | Sticky host read from an empty FIFO |
| level | output | CW (5) | FIFO occupancy |

## Verification
The hardest situation to reach is the DMA last-byte drop when dma_ack has no edge. The acknowledge must already be high, and stay high, before terminal count arrives, so that only the strobe can end the request. The bench therefore restarts a write command and raises dma_ack with tc low. It then raises tc alone and confirms that drq stays up. Only after that does it issue one host write and expect drq to fall. The rising-edge case is covered separately, with tc held first without acknowledge.

// File: rtl/svc_pkg.sv
package svc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SERVE,
        ST_END
    } svc_state_t;

endpackage

// File: rtl/svc_fifo.sv
module svc_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] level,
    output logic [CW-1:0] level_nxt,
    output logic          full,
    output logic          empty
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp, wp_inc, rp_inc;
    logic          push_ok, pop_ok;

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rp];

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wp_inc = wp + AW'(1);
            assign rp_inc = rp + AW'(1);
        end else begin : g_wrap
            assign wp_inc = (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            assign rp_inc = (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
        end
    endgenerate

    always_comb begin
        if (flush) level_nxt = '0;
        else       level_nxt = level + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            level <= level_nxt;
            if (flush) begin
                wp <= '0;
                rp <= '0;
            end else begin
                if (push_ok) wp <= wp_inc;
                if (pop_ok)  rp <= rp_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wp] <= wdata;
    end

endmodule

// File: rtl/svc_thresh.sv
module svc_thresh #(
    parameter int DEPTH    = 16,
    parameter int THR_INIT = 8,
    localparam int TW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [TW-1:0] val,
    output logic [TW-1:0] thr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr <= TW'(THR_INIT);
        end else if (wr) begin
            thr <= (val == '0) ? TW'(1) : val;
        end
    end

endmodule

// File: rtl/svc_req_fsm.sv
module svc_req_fsm
    import svc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          exec_phase,
    input  logic          dir_rd,
    input  logic          dma_mode,
    input  logic          tc,
    input  logic          dma_ack,
    input  logic          strobe,
    input  logic          sector_mark,
    input  logic [CW-1:0] level_nxt,
    input  logic [TW-1:0] thr,
    output logic          req,
    output logic          done
);

    svc_state_t state, state_nxt;
    logic       ack_q;
    logic       sec_q, sec_nxt;
    logic       ack_rise, term;
    logic       rd_hit, wr_hit, drained, filled;

    assign ack_rise = dma_ack && !ack_q;
    assign term     = dma_mode ? (tc && dma_ack && (ack_rise || strobe))
                               : (tc && !dma_ack);
    assign drained  = (level_nxt == '0);
    assign filled   = (level_nxt == CW'(DEPTH));
    assign rd_hit   = !drained &&
                      ((level_nxt >= (CW'(DEPTH) - CW'(thr))) || sec_nxt);
    assign wr_hit   = (level_nxt <= CW'(thr));

    always_comb begin
        if (flush)            sec_nxt = 1'b0;
        else if (sector_mark) sec_nxt = 1'b1;
        else if (drained)     sec_nxt = 1'b0;
        else                  sec_nxt = sec_q;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (exec_phase) begin
                    if (dir_rd) state_nxt = rd_hit ? ST_SERVE : ST_WAIT;
                    else        state_nxt = filled ? ST_WAIT : ST_SERVE;
                end
            end
            ST_WAIT: begin
                if (!exec_phase)          state_nxt = ST_IDLE;
                else if (term)            state_nxt = ST_END;
                else if (dir_rd && rd_hit)  state_nxt = ST_SERVE;
                else if (!dir_rd && wr_hit) state_nxt = ST_SERVE;
            end
            ST_SERVE: begin
                if (!exec_phase)            state_nxt = ST_IDLE;
                else if (term)              state_nxt = ST_END;
                else if (dir_rd && drained) state_nxt = ST_WAIT;
                else if (!dir_rd && filled) state_nxt = ST_WAIT;
            end
            ST_END: begin
                if (!exec_phase) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
        if (flush) state_nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ack_q <= 1'b0;
            sec_q <= 1'b0;
        end else begin
            state <= state_nxt;
            ack_q <= dma_ack;
            sec_q <= sec_nxt;
        end
    end

    always_comb begin
        req  = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_WAIT:  ;
            ST_SERVE: req  = 1'b1;
            ST_END:   done = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/fifo_svc_req.sv
module fifo_svc_req #(
    parameter int DEPTH    = 16,
    parameter int DW       = 8,
    parameter int THR_INIT = 8,
    localparam int TW      = $clog2(DEPTH),
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic          exec_phase,
    input  logic          dir_rd,
    input  logic          dma_mode,
    input  logic          thr_wr,
    input  logic [TW-1:0] thr_val,
    input  logic          dev_push,
    input  logic [DW-1:0] dev_wdata,
    input  logic          last_sector_byte,
    input  logic          dev_pop,
    output logic [DW-1:0] dev_rdata,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          dma_ack,
    input  logic          tc,
    output logic          drq,
    output logic          irq,
    output logic          rqm,
    output logic          result_ok,
    output logic          overrun,
    output logic          underrun,
    output logic [CW-1:0] level
);

    logic          f_push, f_pop, f_full, f_empty;
    logic [DW-1:0] f_wdata, f_rdata;
    logic [CW-1:0] f_level_nxt;
    logic [TW-1:0] thr;
    logic          strobe, req, done;

    assign f_push  = dir_rd ? dev_push : host_wr;
    assign f_pop   = dir_rd ? host_rd : dev_pop;
    assign f_wdata = dir_rd ? dev_wdata : host_wdata;
    assign strobe  = dir_rd ? host_rd : host_wr;

    svc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (cmd_start),
        .push      (f_push),
        .pop       (f_pop),
        .wdata     (f_wdata),
        .rdata     (f_rdata),
        .level     (level),
        .level_nxt (f_level_nxt),
        .full      (f_full),
        .empty     (f_empty)
    );

    svc_thresh #(.DEPTH(DEPTH), .THR_INIT(THR_INIT)) u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (thr_wr),
        .val   (thr_val),
        .thr   (thr)
    );

    svc_req_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (cmd_start),
        .exec_phase  (exec_phase),
        .dir_rd      (dir_rd),
        .dma_mode    (dma_mode),
        .tc          (tc),
        .dma_ack     (dma_ack),
        .strobe      (strobe),
        .sector_mark (dir_rd && dev_push && last_sector_byte),
        .level_nxt   (f_level_nxt),
        .thr         (thr),
        .req         (req),
        .done        (done)
    );

    assign dev_rdata  = f_rdata;
    assign host_rdata = f_rdata;
    assign drq        = req && dma_mode;
    assign irq        = req && !dma_mode;
    assign rqm        = req && !dma_mode;
    assign result_ok  = done && f_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun  <= 1'b0;
            underrun <= 1'b0;
        end else if (cmd_start) begin
            overrun  <= 1'b0;
            underrun <= 1'b0;
        end else begin
            if (host_wr && !dir_rd && f_full)  overrun  <= 1'b1;
            if (host_rd && dir_rd && f_empty)  underrun <= 1'b1;
        end
    end

endmodule

// File: rtl/svc_req_chk.sv
module svc_req_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dir_rd,
    input logic          dma_mode,
    input logic          host_wr,
    input logic          host_rd,
    input logic          cmd_start,
    input logic [CW-1:0] level,
    input logic          drq,
    input logic          irq,
    input logic          overrun,
    input logic          underrun,
    input logic          result_ok
);

    assert_drq_only_dma_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drq |-> dma_mode);

    assert_irq_only_pio_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !dma_mode);

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    assert_result_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        result_ok |-> (level == '0));

    assert_overrun_set_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !dir_rd && level == CW'(DEPTH) && !cmd_start) |=> overrun);

    assert_underrun_set_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && dir_rd && level == '0 && !cmd_start) |=> underrun);

    assert_overrun_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !cmd_start) |=> overrun);

endmodule

bind fifo_svc_req svc_req_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_rd    (dir_rd),
    .dma_mode  (dma_mode),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .cmd_start (cmd_start),
    .level     (level),
    .drq       (drq),
    .irq       (irq),
    .overrun   (overrun),
    .underrun  (underrun),
    .result_ok (result_ok)
);

// File: tb/fifo_svc_req_tb.sv
module fifo_svc_req_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 0, exec_phase = 0, dir_rd = 0, dma_mode = 0;
    logic       thr_wr = 0;
    logic [3:0] thr_val = 0;
    logic       dev_push = 0, last_sector_byte = 0, dev_pop = 0;
    logic [7:0] dev_wdata = 0, host_wdata = 0;
    logic       host_rd = 0, host_wr = 0, dma_ack = 0, tc = 0;
    logic [7:0] dev_rdata, host_rdata;
    logic       drq, irq, rqm, result_ok, overrun, underrun;
    logic [4:0] level;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fifo_svc_req u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .exec_phase(exec_phase),
        .dir_rd(dir_rd), .dma_mode(dma_mode), .thr_wr(thr_wr), .thr_val(thr_val),
        .dev_push(dev_push), .dev_wdata(dev_wdata), .last_sector_byte(last_sector_byte),
        .dev_pop(dev_pop), .dev_rdata(dev_rdata), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .dma_ack(dma_ack), .tc(tc),
        .drq(drq), .irq(irq), .rqm(rqm), .result_ok(result_ok), .overrun(overrun),
        .underrun(underrun), .level(level)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic begin_cmd(input bit rd, input bit dma, input logic [3:0] t);
        exec_phase = 0; tc = 0; dma_ack = 0;
        dir_rd = rd; dma_mode = dma;
        thr_val = t; thr_wr = 1; cmd_start = 1;
        step();
        thr_wr = 0; cmd_start = 0;
        exec_phase = 1;
        step();
    endtask

    task automatic dpush(input logic [7:0] d, input bit lsb);
        dev_push = 1; dev_wdata = d; last_sector_byte = lsb;
        step();
        dev_push = 0; last_sector_byte = 0;
    endtask

    task automatic hread();
        host_rd = 1; step(); host_rd = 0;
    endtask

    task automatic hwrite(input logic [7:0] d);
        host_wr = 1; host_wdata = d; step(); host_wr = 0;
    endtask

    task automatic dpop();
        dev_pop = 1; step(); dev_pop = 0;
    endtask

    task automatic t_reset();
        chk("R1 drq", drq, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rqm", rqm, 0);
        chk("R1 result_ok", result_ok, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 underrun", underrun, 0);
        chk("R1 level", level, 0);
    endtask

    task automatic t_read_threshold();
        begin_cmd(1, 1, 4);
        for (int i = 0; i < 12; i++) begin
            dpush(8'h10 + 8'(i), 0);
            chk("R3 drq vs level", drq, (i + 1 >= 12) ? 1 : 0);
        end
        chk("R8 irq idle in dma", irq, 0);
        for (int i = 0; i < 12; i++) begin
            chk("R2 read order", host_rdata, 8'h10 + i);
            hread();
            chk("R5 drq while draining", drq, (i < 11) ? 1 : 0);
        end
        chk("R2 level empty", level, 0);
    endtask

    task automatic t_sector_last();
        begin_cmd(1, 0, 4);
        dpush(8'h31, 0);
        dpush(8'h32, 0);
        chk("R4 irq below threshold", irq, 0);
        dpush(8'h33, 1);
        chk("R4 irq on sector end", irq, 1);
        chk("R8 rqm in pio", rqm, 1);
        chk("R8 drq in pio", drq, 0);
        for (int i = 0; i < 3; i++) hread();
        chk("R5 irq after drain", irq, 0);
    endtask

    task automatic t_write_fill();
        begin_cmd(0, 1, 4);
        chk("R6 drq on exec entry", drq, 1);
        for (int i = 0; i < 16; i++) begin
            hwrite(8'hA0 + 8'(i));
            if (i >= 14) chk("R6 drq near full", drq, (i == 15) ? 0 : 1);
        end
        chk("R2 level full", level, 16);
        hwrite(8'hEE);
        chk("R13 overrun set", overrun, 1);
        chk("R2 push when full ignored", level, 16);
        for (int j = 0; j < 12; j++) begin
            chk("R2 device order", dev_rdata, 8'hA0 + j);
            dpop();
            chk("R7 drq refill", drq, (16 - (j + 1) <= 4) ? 1 : 0);
        end
        chk("R13 overrun holds", overrun, 1);
    endtask

    task automatic t_dma_ack_edge();
        tc = 1;
        step();
        chk("R9 tc without ack", drq, 1);
        dma_ack = 1;
        hwrite(8'h55);
        chk("R9 drq drop on ack edge", drq, 0);
        dma_ack = 0; tc = 0;
        chk("R11 result with data", result_ok, 0);
        for (int i = 0; i < 4; i++) dpop();
        chk("R11 result one left", result_ok, 0);
        dpop();
        chk("R11 result when empty", result_ok, 1);
    endtask

    task automatic t_dma_strobe();
        begin_cmd(0, 1, 4);
        chk("R6 drq restart", drq, 1);
        dma_ack = 1;
        step();
        step();
        tc = 1;
        step();
        chk("R9 held ack no strobe", drq, 1);
        hwrite(8'h66);
        chk("R9 drq drop on strobe", drq, 0);
        tc = 0; dma_ack = 0;
    endtask

    task automatic t_pio_term();
        begin_cmd(0, 0, 4);
        chk("R8 irq in pio write", irq, 1);
        chk("R8 rqm in pio write", rqm, 1);
        tc = 1;
        step();
        tc = 0;
        chk("R10 irq cut", irq, 0);
        chk("R10 rqm cut", rqm, 0);
        step();
        chk("R10 irq stays cut", irq, 0);
        chk("R11 result after pio term", result_ok, 1);
    endtask

    task automatic t_flags();
        begin_cmd(1, 1, 4);
        hread();
        chk("R13 underrun set", underrun, 1);
        chk("R2 pop when empty ignored", level, 0);
        exec_phase = 0;
        cmd_start = 1;
        step();
        cmd_start = 0;
        chk("R13 underrun cleared", underrun, 0);
        chk("R13 overrun cleared", overrun, 0);
    endtask

    task automatic t_clamp();
        begin_cmd(1, 1, 0);
        thr_val = 9;
        for (int i = 0; i < 15; i++) begin
            dpush(8'(i), 0);
            if (i == 6)  chk("R12 thr_val ignored without strobe", drq, 0);
            if (i == 13) chk("R12 zero clamped below", drq, 0);
            if (i == 14) chk("R12 zero clamped to one", drq, 1);
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        step();
        t_reset();
        t_read_threshold();
        t_sector_last();
        t_write_fill();
        t_dma_ack_edge();
        t_dma_strobe();
        t_pio_term();
        t_flags();
        t_clamp();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule